// File: doc/BRIEF.md
# Dual PI Inductor Current Balancer

This block equalises the mean currents carried by three parallel current-source bridge modules. Every sample strobe it receives the upper and lower inductor current of each module as signed 12-bit counts. It forms each module's mean of the two, then smooths that mean with a first-order recursive low-pass stage. The smoothing corner is near 155 Hz at a 1 MHz strobe rate, which removes the switching ripple.

Two proportional-integral loops work on the smoothed means. One loop acts on the difference between modules one and two and sets the carrier amplitude factor of module two. The other acts on the difference between modules two and three and sets the factor of module three. Each loop output is limited to a narrow band of plus or minus 6 % of full scale and then added to unity. The result is an unsigned Q1.15 multiplier that is applied to the triangular carrier of that module. While control is off, both multipliers sit at exactly unity and the integrators are emptied.

Top module: `ibal_top`

## Requirements
- R1: Each module's mean is floor((hi + lo) / 2), taken from its two signed 12-bit samples.
- R2: On every strobe each module's filter accumulator A is updated as A := A + mean − floor(A / 2^10), starting from 0 at reset. The smoothed value is floor(A / 2^10) of the updated A. The filter runs whether or not control is enabled, and it is frozen on cycles with no strobe.
- R3: The loop for module two uses error e2 = f1 − f2. The loop for module three uses error e3 = f2 − f3. Here f is the smoothed value of R2, taken from the same strobe.
- R4: For each loop, with unsigned gains kp and ki, the raw output is u = floor((kp·e + I) / 2^12). The integrator I adds ki·e on each enabled strobe.
- R5: The loop output is limited to the range −1966 to +1966, so each factor stays within 30802 to 34734.
- R6: Each factor is a 16-bit unsigned Q1.15 value equal to 32768 plus the limited loop output. Reset leaves both factors at 32768.
- R7: Whenever enable is sampled low, the next cycle shows both factors at exactly 32768 and the integrators cleared. This holds even if a strobe arrives in the same cycle.
- R8: Anti-windup: on an enabled strobe, the integrator keeps its old value when the trial value I + ki·e would give a raw output above +1966 while ki·e > 0, or below −1966 while ki·e < 0. Otherwise it takes the trial value. The output is then computed from the kept integrator.
- R9: The factors change only on the clock edge that samples a strobe with enable high, and are visible in the following cycle. They hold steady otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | New current samples valid this cycle |
| ctrl_en | input | 1 | Balancing control enable |
| m1_hi | input | 12 | Module 1 upper inductor current, signed |
| m1_lo | input | 12 | Module 1 lower inductor current, signed |
| m2_hi | input | 12 | Module 2 upper inductor current, signed |
| m2_lo | input | 12 | Module 2 lower inductor current, signed |
| m3_hi | input | 12 | Module 3 upper inductor current, signed |
| m3_lo | input | 12 | Module 3 lower inductor current, signed |
| kp_gain | input | 16 | Proportional gain, unsigned |
| ki_gain | input | 16 | Integral gain, unsigned |
| scale_m2 | output | 16 | Module 2 carrier amplitude factor, unsigned Q1.15 |
| scale_m3 | output | 16 | Module 3 carrier amplitude factor, unsigned Q1.15 |

## Verification
Two functions can fall in the same cycle. The first is output limiting together with the integrator freeze: a large sustained imbalance drives a loop into its limit, and the freeze decision and the clamp are made on the same strobe. The imbalance is then reversed. A loop that wound up would stay pinned far longer than the behavioural model predicts, so it would be caught. The second is enable falling on a strobe cycle: the filter must still advance while the factors return to unity. After re-enable, the model's fresh-integrator trajectory is compared every clock.

// File: rtl/ibal_pkg.sv
package ibal_pkg;

    // wide signed accumulator for the loop arithmetic
    localparam int ACC_W = 48;
    typedef logic signed [ACC_W-1:0] ibal_acc_t;

    // unity in unsigned Q1.15
    localparam logic [15:0] UNITY_Q15 = 16'h8000;

    typedef struct packed {
        ibal_acc_t   integ;
        logic [15:0] scale;
    } pi_state_t;

endpackage

// File: rtl/ibal_avg_lpf.sv
module ibal_avg_lpf
    import ibal_pkg::*;
#(
    parameter int IW      = 12,
    parameter int K_SHIFT = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic signed [IW-1:0] hi,
    input  logic signed [IW-1:0] lo,
    output logic signed [IW-1:0] y_next
);

    localparam int AW = IW + K_SHIFT + 1;

    typedef struct packed {
        logic signed [AW-1:0] acc;
    } lpf_state_t;

    lpf_state_t st_d, st_q;

    logic signed [IW:0]   pair_sum;
    logic signed [IW-1:0] mean;
    logic signed [AW-1:0] mean_x;
    logic signed [AW-1:0] leak;

    always_comb begin
        pair_sum = {hi[IW-1], hi} + {lo[IW-1], lo};
        mean     = IW'(pair_sum >>> 1);
        mean_x   = {{(AW-IW){mean[IW-1]}}, mean};
        leak     = $signed(st_q.acc) >>> K_SHIFT;
        st_d     = st_q;
        if (stb) begin
            st_d.acc = st_q.acc + mean_x - leak;
        end
        y_next = IW'($signed(st_d.acc) >>> K_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LPF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(st_q.acc)); // R2

endmodule

// File: rtl/ibal_pi.sv
module ibal_pi
    import ibal_pkg::*;
#(
    parameter int IW     = 12,
    parameter int GW     = 16,
    parameter int GSHIFT = 12,
    parameter int LIM    = 1966
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic                 en,
    input  logic signed [IW-1:0] fa,
    input  logic signed [IW-1:0] fb,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    output logic [15:0]          scale
);

    localparam ibal_acc_t LIM_W  = ibal_acc_t'(LIM);
    localparam ibal_acc_t UNIT_W = ibal_acc_t'(UNITY_Q15);

    pi_state_t st_d, st_q;

    ibal_acc_t err_w, kp_w, ki_w, p_w, k_w;
    ibal_acc_t i_try, u_try, i_keep, u_raw, u_lim, s_w;
    logic      freeze;

    always_comb begin
        err_w  = {{(ACC_W-IW){fa[IW-1]}}, fa} - {{(ACC_W-IW){fb[IW-1]}}, fb};
        kp_w   = {{(ACC_W-GW){1'b0}}, kp};
        ki_w   = {{(ACC_W-GW){1'b0}}, ki};
        p_w    = err_w * kp_w;
        k_w    = err_w * ki_w;
        i_try  = st_q.integ + k_w;
        u_try  = (p_w + i_try) >>> GSHIFT;
        freeze = ((u_try > LIM_W) && (k_w > 0)) || ((u_try < -LIM_W) && (k_w < 0));
        i_keep = freeze ? st_q.integ : i_try;
        u_raw  = (p_w + i_keep) >>> GSHIFT;
        if (u_raw > LIM_W) begin
            u_lim = LIM_W;
        end else if (u_raw < -LIM_W) begin
            u_lim = -LIM_W;
        end else begin
            u_lim = u_raw;
        end
        s_w  = UNIT_W + u_lim;
        st_d = st_q;
        if (!en) begin
            st_d.integ = '0;
            st_d.scale = UNITY_Q15;
        end else if (stb) begin
            st_d.integ = i_keep;
            st_d.scale = 16'(s_w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.integ <= '0;
            st_q.scale <= UNITY_Q15;
        end else begin
            st_q <= st_d;
        end
    end

    assign scale = st_q.scale;

    AST_INTEG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.integ == '0)); // R7

    AST_FROZEN_WHEN_BALANCED: assert property (@(posedge clk) disable iff (rst)
        (en && stb && (fa == fb)) |=> $stable(st_q.integ)); // R4

endmodule

// File: rtl/ibal_top.sv
module ibal_top
    import ibal_pkg::*;
#(
    parameter int IW      = 12,
    parameter int GW      = 16,
    parameter int K_SHIFT = 10,
    parameter int GSHIFT  = 12,
    parameter int LIM     = 1966
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic                 ctrl_en,
    input  logic signed [IW-1:0] m1_hi,
    input  logic signed [IW-1:0] m1_lo,
    input  logic signed [IW-1:0] m2_hi,
    input  logic signed [IW-1:0] m2_lo,
    input  logic signed [IW-1:0] m3_hi,
    input  logic signed [IW-1:0] m3_lo,
    input  logic [GW-1:0]        kp_gain,
    input  logic [GW-1:0]        ki_gain,
    output logic [15:0]          scale_m2,
    output logic [15:0]          scale_m3
);

    localparam int NMOD  = 3;
    localparam int NLOOP = NMOD - 1;

    logic signed [IW-1:0] hi_a [NMOD];
    logic signed [IW-1:0] lo_a [NMOD];
    logic signed [IW-1:0] filt [NMOD];
    logic [15:0]          sc_a [NLOOP];

    assign hi_a[0] = m1_hi;
    assign hi_a[1] = m2_hi;
    assign hi_a[2] = m3_hi;
    assign lo_a[0] = m1_lo;
    assign lo_a[1] = m2_lo;
    assign lo_a[2] = m3_lo;

    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        ibal_avg_lpf #(.IW(IW), .K_SHIFT(K_SHIFT)) u_lpf (
            .clk    (clk),
            .rst    (rst),
            .stb    (sample_stb),
            .hi     (hi_a[g]),
            .lo     (lo_a[g]),
            .y_next (filt[g])
        );
    end

    // loop j balances module j against module j+1 and scales module j+1
    for (genvar j = 0; j < NLOOP; j++) begin : g_loop
        ibal_pi #(.IW(IW), .GW(GW), .GSHIFT(GSHIFT), .LIM(LIM)) u_pi (
            .clk   (clk),
            .rst   (rst),
            .stb   (sample_stb),
            .en    (ctrl_en),
            .fa    (filt[j]),
            .fb    (filt[j+1]),
            .kp    (kp_gain),
            .ki    (ki_gain),
            .scale (sc_a[j])
        );
    end

    assign scale_m2 = sc_a[0];
    assign scale_m3 = sc_a[1];

    AST_SCALE_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (scale_m2 >= 16'(32768 - LIM)) && (scale_m2 <= 16'(32768 + LIM)) &&
        (scale_m3 >= 16'(32768 - LIM)) && (scale_m3 <= 16'(32768 + LIM))); // R5

    AST_DISABLED_UNITY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> ((scale_m2 == UNITY_Q15) && (scale_m3 == UNITY_Q15))); // R7

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !sample_stb) |=> ($stable(scale_m2) && $stable(scale_m3))); // R9

endmodule

// File: tb/ibal_top_test.sv
`timescale 1ns/1ps
module ibal_top_test;

    localparam int  KS    = 10;
    localparam int  GS    = 12;
    localparam longint LIMV = 1966;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 1'b0;
    logic ctrl_en = 1'b0;
    logic signed [11:0] m1_hi = '0, m1_lo = '0, m2_hi = '0, m2_lo = '0, m3_hi = '0, m3_lo = '0;
    logic [15:0] kp_gain = '0, ki_gain = '0;
    logic [15:0] scale_m2, scale_m3;

    ibal_top uut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .ctrl_en(ctrl_en),
        .m1_hi(m1_hi), .m1_lo(m1_lo), .m2_hi(m2_hi), .m2_lo(m2_lo),
        .m3_hi(m3_hi), .m3_lo(m3_lo), .kp_gain(kp_gain), .ki_gain(ki_gain),
        .scale_m2(scale_m2), .scale_m3(scale_m3)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string req_tag = "R6";
    longint cyc = 0;

    // behavioural reference model
    longint acc[3];
    longint integ[2];
    longint exp_sc[2];

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        longint f[3];
        longint hv[3];
        longint lv[3];
        cyc++;
        if (rst) begin
            for (int m = 0; m < 3; m++) acc[m] = 0;
            for (int j = 0; j < 2; j++) begin integ[j] = 0; exp_sc[j] = 32768; end
        end else begin
            hv[0] = m1_hi; hv[1] = m2_hi; hv[2] = m3_hi;
            lv[0] = m1_lo; lv[1] = m2_lo; lv[2] = m3_lo;
            if (sample_stb) begin
                for (int m = 0; m < 3; m++) begin
                    longint mean;
                    mean = (hv[m] + lv[m]) >>> 1;           // R1
                    acc[m] = acc[m] + mean - (acc[m] >>> KS); // R2
                end
            end
            for (int m = 0; m < 3; m++) f[m] = acc[m] >>> KS;
            if (!ctrl_en) begin
                for (int j = 0; j < 2; j++) begin integ[j] = 0; exp_sc[j] = 32768; end
            end else if (sample_stb) begin
                for (int j = 0; j < 2; j++) begin
                    longint e, p, k, it, ut, u;
                    e  = f[j] - f[j+1];                       // R3
                    p  = e * longint'(kp_gain);
                    k  = e * longint'(ki_gain);
                    it = integ[j] + k;
                    ut = (p + it) >>> GS;
                    if (!((ut > LIMV && k > 0) || (ut < -LIMV && k < 0))) integ[j] = it; // R8
                    u = (p + integ[j]) >>> GS;                // R4
                    if (u > LIMV) u = LIMV;                   // R5
                    if (u < -LIMV) u = -LIMV;
                    exp_sc[j] = 32768 + u;
                end
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired got %0d cycles expected under 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check(req_tag, "scale_m2", longint'(scale_m2), exp_sc[0]);
            check(req_tag, "scale_m3", longint'(scale_m3), exp_sc[1]);
        end
    end

    task automatic set_cur(input int a1, input int b1, input int a2, input int b2, input int a3, input int b3);
        m1_hi = 12'(a1); m1_lo = 12'(b1);
        m2_hi = 12'(a2); m2_lo = 12'(b2);
        m3_hi = 12'(a3); m3_lo = 12'(b3);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
            sample_stb = (gap == 0) ? 1'b1 : ((i % (gap + 1)) == 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk);
        started = 1;
        // R6: reset state is unity
        check("R6", "reset scale_m2", longint'(scale_m2), 32768);
        check("R6", "reset scale_m3", longint'(scale_m3), 32768);

        // R2 / R7: filters run while control is off, factors stay at unity
        req_tag = "R7";
        kp_gain = 16'd300; ki_gain = 16'd8;
        set_cur(900, 700, 600, 500, 400, 300);
        run(2000, 0);
        check("R7", "disabled scale_m2", longint'(scale_m2), 32768);
        check("R7", "disabled scale_m3", longint'(scale_m3), 32768);

        // R2: enabling acts on already converged filters
        req_tag = "R2";
        #0.5 ctrl_en = 1'b1;
        run(500, 0);

        // R1: equal-looking means with a floor in module three
        req_tag = "R1";
        set_cur(1000, 600, 700, 900, 801, 798);
        run(4000, 0);

        // R3: only module one differs; loop for module three sees no error
        req_tag = "R3";
        #0.5 ctrl_en = 1'b0;
        run(4, 0);
        #0.5 ctrl_en = 1'b1;
        set_cur(300, 300, 100, 100, 100, 100);
        run(4000, 0);

        // R9 / R4: sparse strobes with negative currents
        req_tag = "R9";
        set_cur(-200, -260, -150, -100, -300, -320);
        run(3000, 2);
        req_tag = "R4";
        kp_gain = 16'd1200; ki_gain = 16'd3;
        run(2000, 1);

        // R5: large imbalance drives both loops into the limit
        req_tag = "R5";
        kp_gain = 16'd300; ki_gain = 16'd8;
        set_cur(1500, 1500, -1500, -1500, 1500, 1500);
        run(5000, 0);
        check("R5", "upper limit scale_m2", longint'(scale_m2), 32768 + LIMV);
        check("R5", "lower limit scale_m3", longint'(scale_m3), 32768 - LIMV);

        // R8: reversal after saturation; windup would delay recovery
        req_tag = "R8";
        set_cur(-1500, -1500, 1500, 1500, -1500, -1500);
        run(6000, 0);

        // R7: enable falls in a strobe cycle, filters keep running
        req_tag = "R7";
        set_cur(200, 220, 0, 10, -50, -40);
        run(300, 0);
        #0.5 ctrl_en = 1'b0;
        @(negedge clk);
        check("R7", "drop on strobe scale_m2", longint'(scale_m2), 32768);
        check("R7", "drop on strobe scale_m3", longint'(scale_m3), 32768);
        run(200, 0);
        #0.5 ctrl_en = 1'b1;
        run(3000, 0);

        sample_stb = 1'b0;
        run(20, 1000);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule